// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers a set of interrupt sources and presents them to a processor as two active-low lines: a normal interrupt request and a fast interrupt request. Each source has its own enable bit, an active-sense bit and a trigger-mode bit (level or edge), plus a 3-bit priority group. Group 0 is reserved for the fast line. Groups 1 to 7 compete for the normal line, where a numerically lower group is more urgent.

Software reads an encoding register to find the most urgent pending source. The value comes back already multiplied by four, so a handler can add it straight to the base of a table of word-sized vectors. The read also records that source's group on an internal stack of in-service levels. That masks the normal line until a strictly more urgent request appears, which is how nested handlers are supported. An end-of-service write pops the stack. A separate write clears latched edge requests.

Register map (byte addresses on `bus_addr`, word index in bits 7:2): 0x00 encode (read), 0x04 end-of-service (write), 0x08 edge clear (write, one bit per source), 0x0C enable, 0x10 sense, 0x14 trigger mode, 0x18 and up priority words. Each priority word holds eight sources in 4-bit fields, with the group in the low 3 bits of each field. Source k sits in word k/8, field k%8.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset all enables are 0, all sense bits are 1 (active high / rising), all trigger bits are 0 (level), all groups are 0, the level stack is empty, and `irq_n`, `fiq_n` are high.
- R2: A read of the encode register returns, in the next cycle on `bus_rdata`, four times the index of the enabled active source with the numerically lowest nonzero group.
- R3: Among enabled active sources with equal best group, the lowest source index wins.
- R4: When no enabled active source has a nonzero group, the encode read returns four times N_SRC and leaves the level stack unchanged.
- R5: `irq_n` is low when some enabled active source with a nonzero group exists and either the stack is empty or that group is strictly below the stack top. An encode read pushes the winner's group, which deasserts `irq_n` in the cycle after the read.
- R6: While a level is in service, a request of equal or larger group number keeps `irq_n` high, and a strictly smaller group number drives it low again.
- R7: A write to end-of-service pops one stack entry. When the stack is empty the write is ignored.
- R8: The stack holds 8 levels. An encode read with a full stack returns the vector but does not push.
- R9: `fiq_n` is low whenever an enabled active source has group 0, regardless of the stack. Such sources never win the encode read.
- R10: A source whose enable bit is 0 affects neither output nor the encode result.
- R11: A level source with sense bit 0 is active while its input is low.
- R12: An edge source latches a request on a rising edge (sense 1) or a falling edge (sense 0). The request stays pending after the input returns, until an edge-clear write sets its bit.
- R13: The enable, sense, trigger and priority registers read back the values written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | N_SRC | Raw interrupt source inputs |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_n | output | 1 | Active-low normal interrupt request |
| fiq_n | output | 1 | Active-low fast interrupt request |

## Verification
Directed sequences nest requests of different urgency. A lower-urgency arrival while a level is in service is the case that separates correct stacking from a plain "any pending" line. Ties between equal groups, and arrivals that are more urgent than the stack top, separate the index tie-break from the group comparison. Edge sources of both senses are pulsed and then released, so a latched request can be told apart from a level that has already gone away. Random rounds draw inputs, enables and groups, which mixes fast-line and normal-line sources so that the winner choice and the line states are compared against a bench model. A full stack, extra end-of-service writes on an empty stack, and masked sources cover the ignore cases.

// File: rtl/nic_pkg.sv
package nic_pkg;

    localparam int PRIO_W          = 3;
    localparam int DATA_W          = 32;
    localparam int FIELD_W         = 4;
    localparam int FIELDS_PER_WORD = DATA_W / FIELD_W;
    localparam int IDX_W           = 6;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [5:0]        word_t;

    localparam word_t W_ENC   = 6'd0;
    localparam word_t W_EOS   = 6'd1;
    localparam word_t W_ECLR  = 6'd2;
    localparam word_t W_MASK  = 6'd3;
    localparam word_t W_POL   = 6'd4;
    localparam word_t W_TRIG  = 6'd5;
    localparam word_t W_PRIO0 = 6'd6;

    typedef enum logic [1:0] {
        STK_IDLE,
        STK_PUSH,
        STK_POP
    } stk_op_e;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
        prio_t            prio;
    } win_t;

    // a is more urgent than b
    function automatic logic outranks(prio_t a, prio_t b);
        return a < b;
    endfunction

endpackage

// File: rtl/nic_src_cond.sv
module nic_src_cond #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw,
    input  logic [N-1:0] pol,
    input  logic [N-1:0] trig,
    input  logic [N-1:0] clr,
    output logic [N-1:0] active
);

    for (genvar i = 0; i < N; i++) begin : g_src
        logic s1, s2, s3, pend, edge_hit;

        always_ff @(posedge clk) begin
            if (rst) begin
                s1   <= 1'b0;
                s2   <= 1'b0;
                s3   <= 1'b0;
                pend <= 1'b0;
            end else begin
                s1   <= raw[i];
                s2   <= s1;
                s3   <= s2;
                pend <= (pend & ~clr[i]) | (trig[i] & edge_hit);
            end
        end

        assign edge_hit  = pol[i] ? (s2 & ~s3) : (~s2 & s3);
        assign active[i] = trig[i] ? pend : (pol[i] ? s2 : ~s2);
    end

endmodule

// File: rtl/nic_prio_enc.sv
module nic_prio_enc
    import nic_pkg::*;
#(
    parameter int N = 16
) (
    input  logic            [N-1:0] req,
    input  prio_t           [N-1:0] prio,
    output win_t                    win,
    output logic                    fiq_any
);

    always_comb begin
        win     = '0;
        fiq_any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                if (prio[i] == '0) begin
                    fiq_any = 1'b1;
                end else if (!win.valid || !outranks(win.prio, prio[i])) begin
                    win.valid = 1'b1;
                    win.idx   = IDX_W'(i);
                    win.prio  = prio[i];
                end
            end
        end
    end

endmodule

// File: rtl/nic_level_stack.sv
module nic_level_stack
    import nic_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic    clk,
    input  logic    rst,
    input  stk_op_e op,
    input  prio_t   push_prio,
    output logic    empty,
    output logic    full,
    output prio_t   top
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam int SW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    prio_t          slot [DEPTH];
    logic [CW-1:0]  cnt;
    logic [CW-1:0]  cnt_m1;

    assign empty  = (cnt == '0);
    assign full   = (cnt == CW'(DEPTH));
    assign cnt_m1 = cnt - 1'b1;
    assign top    = empty ? '1 : slot[cnt_m1[SW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            case (op)
                STK_PUSH: if (!full)  cnt <= cnt + 1'b1;
                STK_POP:  if (!empty) cnt <= cnt - 1'b1;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && op == STK_PUSH && !full)
            slot[cnt[SW-1:0]] <= push_prio;
    end

    a_r7_pop_empty_ignored: assert property (@(posedge clk) disable iff (rst)
        (op == STK_POP && empty) |=> $stable(cnt));

    a_r8_push_full_ignored: assert property (@(posedge clk) disable iff (rst)
        (op == STK_PUSH && full) |=> $stable(cnt));

    a_r1_reset_empty: assert property (@(posedge clk)
        $past(rst) |-> (cnt == '0));

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nic_pkg::*;
#(
    parameter int N_SRC       = 16,
    parameter int STACK_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_SRC-1:0]  src_in,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_n,
    output logic              fiq_n
);

    word_t                 word;
    logic [N_SRC-1:0]      mask_q, pol_q, trig_q, clr, active, req;
    prio_t [N_SRC-1:0]     prio_q;
    win_t                  win;
    logic                  fiq_any, irq_cond;
    logic                  stk_empty, stk_full;
    prio_t                 stk_top;
    stk_op_e               stk_op;
    logic [31:0]           rd_val;

    assign word = bus_addr[7:2];

    // configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            pol_q  <= '1;
            trig_q <= '0;
            prio_q <= '0;
        end else if (bus_wr) begin
            if (word == W_MASK) mask_q <= bus_wdata[N_SRC-1:0];
            if (word == W_POL)  pol_q  <= bus_wdata[N_SRC-1:0];
            if (word == W_TRIG) trig_q <= bus_wdata[N_SRC-1:0];
            for (int i = 0; i < N_SRC; i++) begin
                if (word == W_PRIO0 + word_t'(i / FIELDS_PER_WORD))
                    prio_q[i] <= bus_wdata[(i % FIELDS_PER_WORD) * FIELD_W +: PRIO_W];
            end
        end
    end

    assign clr = (bus_wr && word == W_ECLR) ? bus_wdata[N_SRC-1:0] : '0;

    nic_src_cond #(.N(N_SRC)) u_cond (
        .clk    (clk),
        .rst    (rst),
        .raw    (src_in),
        .pol    (pol_q),
        .trig   (trig_q),
        .clr    (clr),
        .active (active)
    );

    assign req = active & mask_q;

    nic_prio_enc #(.N(N_SRC)) u_enc (
        .req     (req),
        .prio    (prio_q),
        .win     (win),
        .fiq_any (fiq_any)
    );

    always_comb begin
        stk_op = STK_IDLE;
        if (bus_rd && word == W_ENC && win.valid)
            stk_op = STK_PUSH;
        else if (bus_wr && word == W_EOS)
            stk_op = STK_POP;
    end

    nic_level_stack #(.DEPTH(STACK_DEPTH)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .op        (stk_op),
        .push_prio (win.prio),
        .empty     (stk_empty),
        .full      (stk_full),
        .top       (stk_top)
    );

    assign irq_cond = win.valid && (stk_empty || outranks(win.prio, stk_top));
    assign irq_n    = ~irq_cond;
    assign fiq_n    = ~fiq_any;

    // read mux
    always_comb begin
        rd_val = '0;
        case (word)
            W_ENC:   rd_val = win.valid ? {{(DATA_W-IDX_W-2){1'b0}}, win.idx, 2'b00}
                                        : 32'(N_SRC) << 2;
            W_MASK:  rd_val[N_SRC-1:0] = mask_q;
            W_POL:   rd_val[N_SRC-1:0] = pol_q;
            W_TRIG:  rd_val[N_SRC-1:0] = trig_q;
            default: begin
                for (int i = 0; i < N_SRC; i++) begin
                    if (word == W_PRIO0 + word_t'(i / FIELDS_PER_WORD))
                        rd_val[(i % FIELDS_PER_WORD) * FIELD_W +: PRIO_W] = prio_q[i];
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
    end

    a_r5_read_deasserts: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && word == W_ENC && win.valid && !stk_full)
        |=> (irq_n || !$stable(req)));

    a_r2_enc_aligned: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && word == W_ENC)
        |=> (bus_rdata[1:0] == 2'b00 && bus_rdata[31:2] <= 30'(N_SRC)));

    a_r9_fiq_not_encoded: assert property (@(posedge clk) disable iff (rst)
        (win.valid) |-> (req[win.idx] && prio_q[win.idx] != '0));

endmodule

// File: tb/nest_irq_ctrl_bench.sv
module nest_irq_ctrl_bench;

    localparam int N = 16;
    localparam logic [7:0] A_ENC = 8'h00, A_EOS = 8'h04, A_ECLR = 8'h08,
                           A_MASK = 8'h0C, A_POL = 8'h10, A_TRIG = 8'h14,
                           A_PRIO0 = 8'h18, A_PRIO1 = 8'h1C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [N-1:0] src = '0;
    logic        rd = 1'b0, wr = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_n, fiq_n;

    int total = 0;
    int bad   = 0;
    int pr [N];
    logic [31:0] v;
    logic done = 1'b0;

    always #10 clk = ~clk;

    nest_irq_ctrl #(.N_SRC(N), .STACK_DEPTH(8)) u_nest_irq_ctrl (
        .clk(clk), .rst(rst), .src_in(src), .bus_rd(rd), .bus_wr(wr),
        .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata),
        .irq_n(irq_n), .fiq_n(fiq_n)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bwrite(logic [7:0] a, logic [31:0] d);
        @(negedge clk); wr = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic bread(logic [7:0] a, output logic [31:0] d);
        @(negedge clk); rd = 1'b1; addr = a;
        @(negedge clk); rd = 1'b0; d = rdata;
    endtask

    task automatic write_prio();
        logic [31:0] w0, w1;
        w0 = '0; w1 = '0;
        for (int i = 0; i < 8; i++) begin
            w0[i*4 +: 3] = 3'(pr[i]);
            w1[i*4 +: 3] = 3'(pr[i+8]);
        end
        bwrite(A_PRIO0, w0);
        bwrite(A_PRIO1, w1);
    endtask

    task automatic do_reset();
        src = '0; rd = 1'b0; wr = 1'b0;
        for (int i = 0; i < N; i++) pr[i] = 0;
        @(negedge clk); rst = 1'b1;
        tick(3);
        rst = 1'b0;
        tick(1);
    endtask

    // bench model of the winner over enabled active sources
    function automatic int exp_enc(logic [N-1:0] act);
        int best = 8;
        int idx  = N;
        for (int i = 0; i < N; i++)
            if (act[i] && pr[i] != 0 && pr[i] < best) begin
                best = pr[i];
                idx  = i;
            end
        return idx;
    endfunction

    function automatic logic exp_fiq(logic [N-1:0] act);
        logic f = 1'b0;
        for (int i = 0; i < N; i++)
            if (act[i] && pr[i] == 0) f = 1'b1;
        return f;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog act=running exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // R1 reset state
        chk("R1 irq_n", irq_n, 1);
        chk("R1 fiq_n", fiq_n, 1);
        chk("R1 rdata", rdata, 0);
        bread(A_MASK, v); chk("R1 mask", v, 0);
        bread(A_POL, v);  chk("R1 pol", v, 32'h0000_FFFF);
        bread(A_TRIG, v); chk("R1 trig", v, 0);
        bread(A_ENC, v);  chk("R4 empty enc", v, N * 4);

        // nesting: R2 R3 R5 R6 R7
        pr[3] = 5; pr[7] = 2; pr[9] = 2; pr[12] = 6;
        write_prio();
        bwrite(A_MASK, 32'hFFFF);
        src[3] = 1'b1; tick(5);
        chk("R5 assert", irq_n, 0);
        bread(A_ENC, v); chk("R2 enc src3", v, 12);
        chk("R5 deassert after read", irq_n, 1);
        src[12] = 1'b1; tick(5);
        chk("R6 lower stays quiet", irq_n, 1);
        src[9] = 1'b1; tick(5);
        chk("R6 higher reasserts", irq_n, 0);
        src[7] = 1'b1; tick(5);
        bread(A_ENC, v); chk("R3 tie lowest index", v, 28);
        chk("R5 deassert nested", irq_n, 1);
        bwrite(A_EOS, 0);
        chk("R7 pop exposes level", irq_n, 0);
        bread(A_ENC, v); chk("R6 new vector", v, 28);
        src = '0; tick(5);
        bwrite(A_EOS, 0); bwrite(A_EOS, 0); bwrite(A_EOS, 0);
        chk("R7 idle", irq_n, 1);
        src[12] = 1'b1; tick(5);
        chk("R7 empty pop ignored", irq_n, 0);
        bread(A_ENC, v); chk("R2 enc src12", v, 48);
        bwrite(A_EOS, 0);

        // R10 enable
        chk("R10 enabled", irq_n, 0);
        bwrite(A_MASK, 32'hFFFF & ~(32'h1 << 12));
        chk("R10 masked irq", irq_n, 1);
        bread(A_ENC, v); chk("R10 masked enc", v, N * 4);

        // R9 fast line
        do_reset();
        pr[4] = 3; write_prio();
        bwrite(A_MASK, 32'hFFFF);
        src[0] = 1'b1; tick(5);
        chk("R9 fiq low", fiq_n, 0);
        chk("R9 irq untouched", irq_n, 1);
        src[4] = 1'b1; tick(5);
        bread(A_ENC, v); chk("R9 group0 not encoded", v, 16);
        chk("R9 fiq ignores stack", fiq_n, 0);
        src[0] = 1'b0; tick(5);
        chk("R9 fiq release", fiq_n, 1);

        // R11 active-low level
        do_reset();
        pr[5] = 4; write_prio();
        bwrite(A_POL, 32'hFFFF & ~(32'h1 << 5));
        bwrite(A_MASK, 32'h1 << 5);
        tick(5);
        chk("R11 low input active", irq_n, 0);
        src[5] = 1'b1; tick(5);
        chk("R11 high input idle", irq_n, 1);
        bread(A_POL, v); chk("R13 pol readback", v, 32'hFFDF);

        // R12 edge latching
        do_reset();
        src[10] = 1'b1; tick(5);
        pr[6] = 3; pr[10] = 4; write_prio();
        bwrite(A_TRIG, (32'h1 << 6) | (32'h1 << 10));
        bwrite(A_POL, 32'hFFFF & ~(32'h1 << 10));
        bwrite(A_MASK, (32'h1 << 6) | (32'h1 << 10));
        tick(3);
        chk("R12 no edge yet", irq_n, 1);
        src[6] = 1'b1; tick(3); src[6] = 1'b0; tick(5);
        chk("R12 rising held", irq_n, 0);
        bread(A_ENC, v); chk("R12 enc src6", v, 24);
        bwrite(A_ECLR, 32'h1 << 6);
        bwrite(A_EOS, 0);
        chk("R12 cleared quiet", irq_n, 1);
        bread(A_ENC, v); chk("R12 cleared enc", v, N * 4);
        src[10] = 1'b0; tick(5);
        chk("R12 falling held", irq_n, 0);
        bread(A_ENC, v); chk("R12 enc src10", v, 40);
        bwrite(A_EOS, 0);
        chk("R12 still pending", irq_n, 0);
        bwrite(A_ECLR, 32'h1 << 10);
        chk("R12 falling cleared", irq_n, 1);

        // R8 full stack
        do_reset();
        pr[1] = 7; pr[2] = 3; write_prio();
        bwrite(A_MASK, 32'hFFFF);
        src[1] = 1'b1; tick(5);
        for (int k = 0; k < 8; k++) begin
            bread(A_ENC, v);
            chk("R8 fill enc", v, 4);
        end
        chk("R8 filled quiet", irq_n, 1);
        src[2] = 1'b1; tick(5);
        chk("R8 urgent asserts", irq_n, 0);
        bread(A_ENC, v); chk("R8 enc when full", v, 8);
        chk("R8 push ignored", irq_n, 0);
        src[2] = 1'b0; tick(5);
        for (int k = 0; k < 7; k++) bwrite(A_EOS, 0);
        chk("R8 one level left", irq_n, 1);
        bwrite(A_EOS, 0);
        chk("R8 depth eight", irq_n, 0);

        // R13 readback
        bwrite(A_MASK, 32'h0F0F);
        bread(A_MASK, v); chk("R13 mask readback", v, 32'h0F0F);
        bread(A_PRIO0, v); chk("R13 prio readback", v, 32'h370);
        bwrite(A_TRIG, 32'h00A5);
        bread(A_TRIG, v); chk("R13 trig readback", v, 32'h00A5);

        // random rounds, level sources, empty stack each round
        do_reset();
        for (int it = 0; it < 120; it++) begin
            logic [N-1:0] m, s, act;
            int e;
            for (int i = 0; i < N; i++) pr[i] = $urandom_range(0, 7);
            m = N'($urandom);
            s = N'($urandom);
            write_prio();
            bwrite(A_MASK, 32'(m));
            src = s;
            tick(5);
            act = s & m;
            e = exp_enc(act);
            chk("R5 random irq", irq_n, (e == N) ? 1 : 0);
            chk("R9 random fiq", fiq_n, exp_fiq(act) ? 0 : 1);
            bread(A_ENC, v);
            chk("R2 random enc", v, 32'(e * 4));
            if (e != N) begin
                chk("R5 random deassert", irq_n, 1);
                bwrite(A_EOS, 0);
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule